// File: doc/BRIEF.md
# Luminance Gamma Curve Unit

The unit reshapes a 10-bit luminance stream into 8-bit output codes through a programmable curve built from ten straight segments. The segment end points sit at fixed, non-uniform input positions; only the output level at each of the eleven end points is programmable. Because every segment is a power of two wide, the interpolation needs no divider: it is a signed multiply, a rounding add and a shift. The curve therefore also compresses the range, since the valid input span of 0 to 896 maps onto 0 to 255.

Samples enter with a valid strobe and leave exactly two clock cycles later with the strobe carried alongside them. A single-cycle write port loads the eleven knot levels. Any write that breaks the non-decreasing order of the knots, judged against the current neighbouring knots, sets a sticky error flag. The offending value is stored anyway.

Top module: `gamma_pwl`

## Requirements
- R1: After reset, valid_o and err_o are 0. Each knot k holds floor((B(k)*255 + 448) / 896). Here B(0..10) = 0, 16, 32, 64, 128, 256, 384, 512, 640, 768, 896.
- R2: A sample accepted with valid_i high at a clock edge appears on y_o with valid_o high after the second following edge. Back-to-back samples stream at one per cycle in order, and valid_o is low whenever valid_i was low two edges before.
- R3: For an input x with B(s) <= x < B(s+1), s in 0..9, the output lies on segment s. At x = B(s) the output equals knot s exactly.
- R4: Inside segment s of width W = B(s+1)-B(s), y = Y(s) + floor(((Y(s+1)-Y(s))*(x-B(s)) + W/2) / W). The difference is signed, so the result rounds half up and lies between the two knots.
- R5: Any input x >= 896, up to 1023, gives y = Y(10).
- R6: When wr_en_i is high with wr_idx_i in 0..10, knot wr_idx_i takes wr_data_i at that edge. A sample accepted on a later edge uses the new value.
- R7: A write with wr_idx_i in 11..15 changes no knot and does not touch err_o.
- R8: err_o rises after a write whose data is below the current knot at index-1 or above the current knot at index+1. Equal values are legal. The written value is still stored.
- R9: Once set, err_o stays high until rst_ni is asserted.
- R10: With a non-monotonic curve loaded, a falling segment is interpolated with the same signed rule as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| luma_i | input | 10 | Input luminance |
| wr_en_i | input | 1 | Knot write strobe |
| wr_idx_i | input | 4 | Knot index to write |
| wr_data_i | input | 8 | Knot level to write |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | 8 | Corrected output code |
| err_o | output | 1 | Sticky non-monotonic write flag |

## Verification
A full sweep of all 1024 codes against the reset curve covers every segment width, both rounding directions and the clamp region above 896. Inputs placed exactly on the breakpoints and one code below them separate a wrong segment decision from a wrong interpolation. A steep reprogrammed curve, loaded top-down so that no write trips the flag, shows that the written knots take effect. A deliberate dip then exercises the error flag, the storing of the offending knot, and the falling-segment rounding. Writes to out-of-range indices followed by a re-sweep show that nothing changed.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int LUMA_W = 10;
  localparam int Y_W    = 8;
  localparam int N_SEG  = 10;
  localparam int N_KNOT = N_SEG + 1;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 7;   // widest segment is 128
  localparam int SH_W   = 3;

  // fixed input breakpoints
  function automatic int bp(int i);
    if (i == 0)     return 0;
    else if (i < 4) return 8 << i;
    else            return (i - 3) * 128;
  endfunction

  // log2 of segment width
  function automatic int seg_shift(int s);
    if (s < 2)      return 4;
    else if (s < 4) return s + 3;
    else            return 7;
  endfunction

  // reset curve: straight line from 0 to full scale at the last breakpoint
  function automatic int default_knot(int i);
    return (bp(i) * ((1 << Y_W) - 1) + bp(N_SEG) / 2) / bp(N_SEG);
  endfunction
endpackage

// File: rtl/gamma_knot_bank.sv
module gamma_knot_bank
  import gamma_pkg::*;
#(
  parameter int NK = N_KNOT,
  parameter int YW = Y_W,
  parameter int IW = IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [YW-1:0]          wr_data_i,
  output logic [NK-1:0][YW-1:0]  knot_o,
  output logic                   err_o
);
  logic [NK-1:0][YW-1:0] knot_q;
  logic [NK-1:0]         bad;
  logic                  err_q;

  for (genvar k = 0; k < NK; k++) begin : g_knot
    logic hit, lo_bad, hi_bad;
    assign hit = wr_en_i && (wr_idx_i == IW'(k));
    if (k == 0) begin : g_lo0
      assign lo_bad = 1'b0;
    end else begin : g_lo
      assign lo_bad = wr_data_i < knot_q[k-1];
    end
    if (k == NK - 1) begin : g_hiN
      assign hi_bad = 1'b0;
    end else begin : g_hi
      assign hi_bad = wr_data_i > knot_q[k+1];
    end
    assign bad[k] = hit && (lo_bad || hi_bad);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  knot_q[k] <= YW'(default_knot(k));
      else if (hit) knot_q[k] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | (|bad);
  end

  assign knot_o = knot_q;
  assign err_o  = err_q;

  for (genvar k = 0; k < NK - 1; k++) begin : g_chk
    assert_knots_ordered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !err_q |-> knot_q[k] <= knot_q[k+1]);
  end

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  assert_bad_index_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= IW'(NK)) |=> ($stable(knot_q) && $stable(err_q)));
endmodule

// File: rtl/gamma_seg_sel.sv
module gamma_seg_sel
  import gamma_pkg::*;
#(
  parameter int LW = LUMA_W,
  parameter int YW = Y_W,
  parameter int NS = N_SEG,
  parameter int OW = OFF_W,
  parameter int SW = SH_W
) (
  input  logic [LW-1:0]           luma_i,
  input  logic [NS:0][YW-1:0]     knot_i,
  output logic [YW-1:0]           ylo_o,
  output logic signed [YW:0]      diff_o,
  output logic [OW-1:0]           off_o,
  output logic [SW-1:0]           sh_o
);
  localparam int SEG_W = $clog2(NS + 1);

  logic [NS:1]      ge;
  logic [SEG_W-1:0] seg;
  logic             clamp;
  logic [LW-1:0]    base;
  logic [YW-1:0]    yhi;

  for (genvar i = 1; i <= NS; i++) begin : g_cmp
    localparam logic [LW-1:0] BP = LW'(bp(i));
    assign ge[i] = luma_i >= BP;
  end

  assign clamp = ge[NS];
  assign seg   = SEG_W'($countones(ge[NS-1:1]));

  always_comb begin
    base  = '0;
    ylo_o = knot_i[NS];
    yhi   = knot_i[NS];
    sh_o  = '0;
    for (int s = 0; s < NS; s++) begin
      if (!clamp && seg == SEG_W'(s)) begin
        base  = LW'(bp(s));
        ylo_o = knot_i[s];
        yhi   = knot_i[s+1];
        sh_o  = SW'(seg_shift(s));
      end
    end
  end

  logic [LW-1:0] off_full;
  assign off_full = luma_i - base;
  assign off_o    = clamp ? '0 : off_full[OW-1:0];
  assign diff_o   = $signed({1'b0, yhi}) - $signed({1'b0, ylo_o});
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
  import gamma_pkg::*;
#(
  parameter int YW = Y_W,
  parameter int OW = OFF_W,
  parameter int SW = SH_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [YW-1:0]        ylo_i,
  input  logic signed [YW:0]   diff_i,
  input  logic [OW-1:0]        off_i,
  input  logic [SW-1:0]        sh_i,
  output logic                 valid_o,
  output logic [YW-1:0]        y_o
);
  localparam int PW = YW + OW + 3;

  logic signed [PW-1:0] prod, half, rnd, sum, lo_s, hi_s;

  assign prod = PW'(diff_i) * PW'($signed({1'b0, off_i}));
  assign half = (sh_i == '0) ? '0 : (PW'(1) <<< (sh_i - SW'(1)));
  assign rnd  = (prod + half) >>> sh_i;
  assign lo_s = PW'($signed({1'b0, ylo_i}));
  assign hi_s = lo_s + PW'(diff_i);
  assign sum  = lo_s + rnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= sum[YW-1:0];
    end
  end

  assert_between_knots_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((diff_i >= 0) ? (sum >= lo_s && sum <= hi_s)
                               : (sum <= lo_s && sum >= hi_s)));
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
  import gamma_pkg::*;
#(
  parameter int LW = LUMA_W,
  parameter int YW = Y_W,
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [LW-1:0] luma_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [YW-1:0] wr_data_i,
  output logic          valid_o,
  output logic [YW-1:0] y_o,
  output logic          err_o
);
  localparam int NK = N_SEG + 1;

  logic [NK-1:0][YW-1:0] knot;
  logic [YW-1:0]         ylo_d, s1_ylo;
  logic signed [YW:0]    diff_d, s1_diff;
  logic [OFF_W-1:0]      off_d, s1_off;
  logic [SH_W-1:0]       sh_d, s1_sh;
  logic                  s1_valid;

  gamma_knot_bank #(.NK(NK), .YW(YW), .IW(IW)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i,
    .knot_o(knot), .err_o
  );

  gamma_seg_sel #(.LW(LW), .YW(YW), .NS(N_SEG), .OW(OFF_W), .SW(SH_W)) u_sel (
    .luma_i, .knot_i(knot),
    .ylo_o(ylo_d), .diff_o(diff_d), .off_o(off_d), .sh_o(sh_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_ylo   <= '0;
      s1_diff  <= '0;
      s1_off   <= '0;
      s1_sh    <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_ylo  <= ylo_d;
        s1_diff <= diff_d;
        s1_off  <= off_d;
        s1_sh   <= sh_d;
      end
    end
  end

  gamma_interp #(.YW(YW), .OW(OFF_W), .SW(SH_W)) u_interp (
    .clk_i, .rst_ni,
    .valid_i(s1_valid), .ylo_i(s1_ylo), .diff_i(s1_diff),
    .off_i(s1_off), .sh_i(s1_sh),
    .valid_o, .y_o
  );

  assert_valid_two_cycles_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  assert_idle_two_cycles_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);
  assert_clamp_top_knot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && luma_i >= LW'(bp(N_SEG))) |=> ##1 (y_o == $past(knot[NK-1])));
  assert_zero_hits_knot0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && luma_i == '0) |=> ##1 (y_o == $past(knot[0])));
endmodule

// File: tb/gamma_pwl_bench.sv
module gamma_pwl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [9:0] luma_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_idx_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       valid_o;
  logic [7:0] y_o;
  logic       err_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mk[11];
  bit merr;
  int expq[$];

  always #2.5 clk = ~clk;

  gamma_pwl u_gamma_pwl (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .luma_i,
    .wr_en_i, .wr_idx_i, .wr_data_i, .valid_o, .y_o, .err_o
  );

  function automatic int brk(int i);
    int t[11] = '{0, 16, 32, 64, 128, 256, 384, 512, 640, 768, 896};
    return t[i];
  endfunction

  function automatic int model(int x);
    int s, w, sh, p;
    if (x >= 896) return mk[10];
    s = 0;
    for (int i = 1; i <= 9; i++) if (x >= brk(i)) s = i;
    w = brk(s + 1) - brk(s);
    sh = $clog2(w);
    p = (mk[s + 1] - mk[s]) * (x - brk(s)) + w / 2;
    return mk[s] + (p >>> sh);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 11; i++) mk[i] = (brk(i) * 255 + 448) / 896;
    merr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid_o after reset", valid_o, 0);
    chk(err_o == 1'b0, "R1 err_o after reset", err_o, 0);
  endtask

  task automatic send(int x);
    @(negedge clk);
    valid_i = 1'b1;
    luma_i = 10'(x);
    expq.push_back(model(x));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic wr(int idx, int data);
    @(negedge clk);
    valid_i = 1'b0;
    wr_en_i = 1'b1;
    wr_idx_i = 4'(idx);
    wr_data_i = 8'(data);
    if (idx <= 10) begin
      if ((idx > 0 && data < mk[idx - 1]) || (idx < 10 && data > mk[idx + 1])) merr = 1;
      mk[idx] = data;
    end
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(err_o == merr, "R8/R9 err_o after write", err_o, merr);
  endtask

  // monitor: compare results against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected valid_o", 1, 0);
        end else begin
          int e;
          e = expq.pop_front();
          chk(int'(y_o) == e, "R3/R4/R5/R10 y_o", y_o, e);
        end
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_reset();

    // R2: single sample latency
    send(100);
    @(negedge clk);
    valid_i = 1'b0;
    chk(valid_o == 1'b0, "R2 valid_o one edge after", valid_o, 0);
    @(negedge clk);
    chk(valid_o == 1'b1, "R2 valid_o two edges after", valid_o, 1);
    idle(3);

    // R1/R3: reset curve at breakpoints and one below each
    for (int i = 0; i <= 10; i++) begin
      send(brk(i));
      if (i > 0) send(brk(i) - 1);
    end
    idle(4);

    // R4/R5: full sweep back to back
    for (int x = 0; x < 1024; x++) send(x);
    idle(4);

    // R5: clamp region
    send(896); send(897); send(1000); send(1023);
    idle(4);

    // R6: steep curve loaded top-down, no error expected
    begin
      int c[11] = '{0, 40, 70, 110, 150, 190, 210, 225, 238, 248, 255};
      for (int i = 10; i >= 0; i--) wr(i, c[i]);
    end
    chk(err_o == 1'b0, "R8 no error for ordered writes", err_o, 0);
    for (int x = 0; x < 1024; x += 3) send(x);
    send(896); send(1023);
    idle(4);

    // R7: out-of-range indices ignored
    wr(11, 0); wr(13, 255); wr(15, 7);
    chk(err_o == 1'b0, "R7 err_o untouched", err_o, 0);
    for (int i = 0; i <= 10; i++) send(brk(i));
    for (int x = 1; x < 1024; x += 7) send(x);
    idle(4);

    // R8/R10: dip stored despite error, falling segment interpolated
    wr(5, 3);
    chk(err_o == 1'b1, "R8 err_o on dip", err_o, 1);
    for (int x = 100; x < 400; x++) send(x);
    idle(4);

    // R9: sticky through a legal write
    wr(5, 170);
    chk(err_o == 1'b1, "R9 err_o stays set", err_o, 1);
    wr(0, 200);
    for (int x = 0; x < 40; x++) send(x);
    idle(4);

    // R1/R9: reset clears flag and restores curve
    do_reset();
    for (int x = 0; x < 1024; x += 5) send(x);
    idle(4);

    chk(expq.size() == 0, "R2 all samples returned", expq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule